// File: doc/BRIEF.md
# Programmable Clock Divider with Low-Power Mode Control

This block turns a fast input clock into a single-cycle system clock enable whose spacing software chooses. An 8-bit control word, written and read back through a simple register port, holds a two-bit ratio code, a low-power override, an automatic-return enable and a stop request. The enable pulse fires once every N input cycles. N is 1, 2, 4 or 8 in normal operation and 256 while the low-power override is set.

A new ratio is picked up only when the running period ends. The enable spacing therefore never shows a truncated or stretched interval. A wake event clears the stop request. When automatic return is enabled, the same wake event also drops the block out of low-power mode. Lock and ready indications from the external oscillator circuitry are sampled and shown as read-only bits in the same word.

Top module: `clkdiv_pwr_ctrl`

## Requirements
- R1: After reset, control bits [4:0] read 0, stop_req is 0 and sys_ce is high on every cycle (ratio 1).
- R2: With bit 2 clear, ratio code bits [1:0] = 00, 01, 10 and 11 give sys_ce pulse spacings of 1, 2, 4 and 8 input cycles.
- R3: With bit 2 set, the sys_ce spacing is 256 input cycles whatever bits [1:0] hold.
- R4: When bit 3 and bit 2 are both set and wake_evt is high with no write in that cycle, bit 2 reads 0 after the next clock. With bit 3 clear, wake_evt leaves bit 2 unchanged.
- R5: Writing 1 to bit 4 drives stop_req high after the next clock. A wake_evt cycle with no write clears bit 4 and stop_req after the next clock.
- R6: A ratio write takes effect only at the end of the running period. Every interval between sys_ce pulses equals the ratio that was in force when that interval began.
- R7: rd_data bit 5 shows fll_locked_in and bit 6 shows xtal_ready_in, each one clock late. Bit 7 always reads 0.
- R8: Write data in bits [7:5] is ignored.
- R9: When a write and wake_evt fall in the same cycle, the written value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-frequency input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write data |
| rd_data | output | 8 | Control and status read-back |
| wake_evt | input | 1 | Wake event pulse |
| fll_locked_in | input | 1 | Frequency-locked-loop lock indication |
| xtal_ready_in | input | 1 | Low-frequency clock ready indication |
| sys_ce | output | 1 | System clock enable pulse |
| stop_req | output | 1 | Stop mode request |

## Verification
A vector table steps through every ratio code. It also sets the low-power bit under several different ratio codes, which separates a correct 256 override from one that mixes in the code bits. Each setting is measured over two consecutive intervals, so a reload that is off by one is caught. A write made mid-period checks that the old interval finishes at full length. Wake pulses are applied with the return enable set, with it clear, and in the same cycle as a write, which distinguishes the clearing paths and their priority.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int DIV_W   = 2;
  localparam int LP_LOG2 = 8;
  localparam int RATIO_W = LP_LOG2 + 1;
  localparam int CNT_W   = LP_LOG2;
  localparam int REG_W   = 8;

  // bit 4 stop, bit 3 auto-return, bit 2 low-power, bits [1:0] ratio code
  typedef struct packed {
    logic             stop;
    logic             auto_ret;
    logic             lowpwr;
    logic [DIV_W-1:0] code;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  function automatic logic [RATIO_W-1:0] ratio_of(ctrl_t c);
    logic [RATIO_W-1:0] one;
    one = RATIO_W'(1);
    if (c.lowpwr) return one << LP_LOG2;
    return one << c.code;
  endfunction
endpackage

// File: rtl/clkdiv_ctrl_reg.sv
module clkdiv_ctrl_reg
  import clkdiv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_bits,
  input  logic              wake_evt,
  input  logic              fll_locked_in,
  input  logic              xtal_ready_in,
  output ctrl_t             ctrl,
  output logic [1:0]        status_q,
  output logic              wake_lp_clr,
  output logic              wake_stop_clr
);
  assign wake_lp_clr   = !wr_en && wake_evt && ctrl.auto_ret && ctrl.lowpwr;
  assign wake_stop_clr = !wr_en && wake_evt && ctrl.stop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl     <= '0;
      status_q <= '0;
    end else begin
      status_q <= {xtal_ready_in, fll_locked_in};
      if (wr_en) begin
        ctrl <= ctrl_t'(wr_bits);
      end else begin
        if (wake_lp_clr)   ctrl.lowpwr <= 1'b0;
        if (wake_stop_clr) ctrl.stop   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/clkdiv_period_cnt.sv
module clkdiv_period_cnt #(
  parameter int CNT_W   = 8,
  parameter int RATIO_W = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [RATIO_W-1:0] ratio,
  output logic               ce
);
  logic [CNT_W-1:0] cnt;
  logic [RATIO_W-1:0] reload;

  assign reload = ratio - RATIO_W'(1);
  assign ce     = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)  cnt <= '0;
    else if (ce) cnt <= reload[CNT_W-1:0];
    else         cnt <= cnt - CNT_W'(1);
  end
endmodule

// File: rtl/clkdiv_pwr_ctrl.sv
module clkdiv_pwr_ctrl
  import clkdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             wake_evt,
  input  logic             fll_locked_in,
  input  logic             xtal_ready_in,
  output logic             sys_ce,
  output logic             stop_req
);
  ctrl_t              ctrl;
  logic [1:0]         status_q;
  logic               wake_lp_clr;
  logic               wake_stop_clr;
  logic [RATIO_W-1:0] next_ratio;
  logic               unused_hi;

  assign unused_hi = ^wr_data[REG_W-1:CTRL_W];

  clkdiv_ctrl_reg i_reg (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_bits       (wr_data[CTRL_W-1:0]),
    .wake_evt      (wake_evt),
    .fll_locked_in (fll_locked_in),
    .xtal_ready_in (xtal_ready_in),
    .ctrl          (ctrl),
    .status_q      (status_q),
    .wake_lp_clr   (wake_lp_clr),
    .wake_stop_clr (wake_stop_clr)
  );

  assign next_ratio = ratio_of(ctrl);

  clkdiv_period_cnt #(.CNT_W(CNT_W), .RATIO_W(RATIO_W)) i_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .ratio (next_ratio),
    .ce    (sys_ce)
  );

  assign rd_data  = {1'b0, status_q, ctrl};
  assign stop_req = ctrl.stop;
endmodule

// File: rtl/clkdiv_pwr_ctrl_chk.sv
module clkdiv_pwr_ctrl_chk
  import clkdiv_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [REG_W-1:0]   wr_data,
  input logic [REG_W-1:0]   rd_data,
  input logic               wake_evt,
  input logic               fll_locked_in,
  input logic               sys_ce,
  input logic               stop_req,
  input logic [RATIO_W-1:0] next_ratio
);
  logic [RATIO_W-1:0] gap;
  logic [RATIO_W-1:0] per;
  logic               seen;
  logic               up_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap <= '0; per <= '0; seen <= 1'b0; up_q <= 1'b0;
    end else begin
      up_q <= 1'b1;
      if (sys_ce) begin
        gap <= RATIO_W'(1); per <= next_ratio; seen <= 1'b1;
      end else begin
        gap <= gap + RATIO_W'(1);
      end
    end
  end

  p_period_exact_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && sys_ce) |-> (gap == per));
  p_wake_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && wake_evt && rd_data[3] && rd_data[2]) |=> !rd_data[2]);
  p_hold_lp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !rd_data[3] && rd_data[2]) |=> rd_data[2]);
  p_stop_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[4]) |=> stop_req);
  p_stop_wake_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && wake_evt) |=> !stop_req);
  p_write_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_data[4:0] == $past(wr_data[4:0])));
  p_lock_mirror_r7: assert property (@(posedge clk) disable iff (!rst_n)
    up_q |-> (rd_data[5] == $past(fll_locked_in)));
  p_top_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[7]);
endmodule

bind clkdiv_pwr_ctrl clkdiv_pwr_ctrl_chk i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .wr_en         (wr_en),
  .wr_data       (wr_data),
  .rd_data       (rd_data),
  .wake_evt      (wake_evt),
  .fll_locked_in (fll_locked_in),
  .sys_ce        (sys_ce),
  .stop_req      (stop_req),
  .next_ratio    (next_ratio)
);

// File: tb/test_clkdiv_pwr_ctrl.sv
module test_clkdiv_pwr_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       wake_evt = 1'b0;
  logic       fll_locked_in = 1'b0;
  logic       xtal_ready_in = 1'b0;
  logic       sys_ce;
  logic       stop_req;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  clkdiv_pwr_ctrl i_clkdiv_pwr_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .wake_evt(wake_evt), .fll_locked_in(fll_locked_in),
    .xtal_ready_in(xtal_ready_in), .sys_ce(sys_ce), .stop_req(stop_req)
  );

  // {write value, expected spacing}
  localparam logic [16:0] VEC [8] = '{
    {8'h00, 9'd1}, {8'h01, 9'd2}, {8'h02, 9'd4}, {8'h03, 9'd8},
    {8'h04, 9'd256}, {8'h07, 9'd256}, {8'h06, 9'd256}, {8'h01, 9'd2}
  };

  function automatic int spacing_for(logic [7:0] w);
    if (w[2]) return 256;
    case (w[1:0])
      2'b00: return 1;
      2'b01: return 2;
      2'b10: return 4;
      default: return 8;
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write(logic [7:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse_wake();
    @(negedge clk); wake_evt = 1'b1;
    @(negedge clk); wake_evt = 1'b0;
  endtask

  task automatic wait_ce();
    while (!sys_ce) @(negedge clk);
  endtask

  task automatic measure(output int g);
    g = 0;
    do begin @(negedge clk); g++; end while (!sys_ce);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int g;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 ctrl", int'(rd_data[4:0]), 0);
    check("R1 stop", int'(stop_req), 0);
    measure(g); check("R1 ratio", g, 1);

    // R2 R3 vector table
    for (int i = 0; i < 8; i++) begin
      write(VEC[i][16:9]);
      wait_ce();
      measure(g); check("R2/R3 first", g, int'(VEC[i][8:0]));
      measure(g); check("R2/R3 second", g, spacing_for(VEC[i][16:9]));
    end

    // R6: ratio write in mid-period
    write(8'h03);
    wait_ce(); measure(g);
    wr_en = 1'b1; wr_data = 8'h00; g = 0;
    do begin @(negedge clk); wr_en = 1'b0; g++; end while (!sys_ce);
    check("R6 old period kept", g, 8);
    measure(g); check("R6 new period", g, 1);

    // R4 auto return
    write(8'h0C);
    check("R4 lp set", int'(rd_data[2]), 1);
    pulse_wake();
    check("R4 lp cleared", int'(rd_data[2]), 0);
    wait_ce(); measure(g); check("R4 ratio after exit", g, 1);
    write(8'h04);
    pulse_wake();
    check("R4 lp held", int'(rd_data[2]), 1);

    // R5 stop
    write(8'h10);
    check("R5 stop set", int'(stop_req), 1);
    pulse_wake();
    check("R5 stop cleared", int'(stop_req), 0);
    check("R5 bit4", int'(rd_data[4]), 0);

    // R9 write and wake together
    @(negedge clk); wr_en = 1'b1; wr_data = 8'h1C; wake_evt = 1'b1;
    @(negedge clk); wr_en = 1'b0; wake_evt = 1'b0;
    check("R9 write wins", int'(rd_data[4:0]), 'h1C);

    // R8 R7
    write(8'hFF);
    check("R8 high bits ignored", int'(rd_data), 'h1F);
    @(negedge clk); fll_locked_in = 1'b1;
    @(negedge clk);
    check("R7 lock", int'(rd_data[6:5]), 1);
    xtal_ready_in = 1'b1;
    @(negedge clk);
    check("R7 ready", int'(rd_data[7:5]), 3);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule